// File: doc/BRIEF.md
# APB Region Protection Filter

This block sits on an APB path between one manager and the subordinates behind it. It checks each transfer's requester context against a fixed table of address windows. The context arrives on the three protection sideband bits. Each window states three things: whether the requester must be privileged, whether it must be secure, and whether instruction fetches are barred.

When a transfer is allowed, it goes through to the downstream side unchanged. The downstream ready, read data and error then come straight back to the manager. When a transfer is refused, the downstream side never sees a select. The filter itself completes the transfer in the first access cycle with an error and zero read data, so nothing is read, nothing is written and no secret can appear on the bus.

The verdict is taken in the setup cycle and kept until the transfer completes. Changes to the sideband or address bits during the access phase therefore cannot turn a refusal into a grant, or a grant into a refusal. Addresses outside every window pass through without a check. Where windows overlap, the lowest-numbered window decides.

Top module: `apb_prot_filter`

## Requirements
- R1: A window with its need-privilege bit set refuses a transfer whose protection bit 0 is 0 (unprivileged) and grants one whose bit 0 is 1.
- R2: A window with its need-secure bit set refuses a transfer whose protection bit 1 is 1 (non-secure) and grants one whose bit 1 is 0 (secure).
- R3: A window with its execute-never bit set refuses a transfer whose protection bit 2 is 1 (instruction) and grants a data access (bit 2 is 0).
- R4: An address that lies in no window is forwarded downstream with no protection check, whatever the protection bits are.
- R5: For a refused transfer, the downstream select and enable stay low in both the setup and the access cycle, so a refused write leaves downstream storage unchanged.
- R6: A refused transfer completes in its first access cycle with ready=1, error=1 and read data equal to zero.
- R7: A granted transfer returns the downstream ready, read data and error unchanged, for any number of downstream wait states.
- R8: The upstream error output is 0 in every cycle that is not a completing access cycle, including reset, idle, setup and wait cycles.
- R9: The verdict is fixed in the setup cycle. Changing the protection bits during the access phase alters neither the grant nor the refusal.
- R10: When windows overlap, the policy of the lowest-indexed matching window alone decides the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_psel | input | 1 | Select from the manager |
| s_penable | input | 1 | Enable (access phase) from the manager |
| s_pwrite | input | 1 | Write direction from the manager |
| s_paddr | input | ADDR_W | Address from the manager |
| s_pwdata | input | DATA_W | Write data from the manager |
| s_pprot | input | 3 | Requester context: bit0 privileged, bit1 non-secure, bit2 instruction |
| s_pready | output | 1 | Completion to the manager |
| s_prdata | output | DATA_W | Read data to the manager (zero when refused) |
| s_pslverr | output | 1 | Error to the manager |
| m_psel | output | 1 | Select to the subordinates (low when refused) |
| m_penable | output | 1 | Enable to the subordinates (low when refused) |
| m_pwrite | output | 1 | Write direction to the subordinates |
| m_paddr | output | ADDR_W | Address to the subordinates |
| m_pwdata | output | DATA_W | Write data to the subordinates |
| m_pprot | output | 3 | Requester context to the subordinates |
| m_pready | input | 1 | Completion from the subordinates |
| m_prdata | input | DATA_W | Read data from the subordinates |
| m_pslverr | input | 1 | Error from the subordinates |

## Verification
Every cycle, the embedded properties check four things. A refusal taken at setup yields a one-cycle error completion with zero data and a silent downstream side. The error line is low outside completions. A granted access mirrors the downstream ready and data. The downstream select does not change across wait states. Only the bench scenarios can show that each policy bit refuses the right context with the right polarity, that overlapping windows resolve by index, and that unmapped space goes unchecked. They also show that a refused write leaves stored data unchanged, which the bench confirms by reading the location back through a permitted access.

// File: rtl/prot_filter_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the region protection filter.
// Assumes the protection sideband encoding: bit0=1 privileged,
// bit1=1 non-secure, bit2=1 instruction fetch.
package prot_filter_pkg;

    localparam int PROT_W         = 3;
    localparam int PROT_PRIV_BIT  = 0;
    localparam int PROT_NSEC_BIT  = 1;
    localparam int PROT_INSTR_BIT = 2;

    // Per-window rule; packed so bit 0 is need_priv, bit 2 is exec_never.
    typedef struct packed {
        logic exec_never;
        logic need_secure;
        logic need_priv;
    } win_rule_t;

    localparam int RULE_W = $bits(win_rule_t);

endpackage

// File: rtl/prot_window_check.sv
`timescale 1ns/1ps
// One address window: flags whether the address falls inside it and
// whether the requester context breaks the window's rule.
// Assumes OFFS_MASK has ones on the offset bits of a power-of-two window.
module prot_window_check
    import prot_filter_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE     = '0,
    parameter logic [ADDR_W-1:0] OFFS_MASK = '1,
    parameter win_rule_t        RULE      = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PROT_W-1:0] prot,
    output logic              hit,
    output logic              breach
);

    localparam logic [ADDR_W-1:0] TAG_MASK = ~OFFS_MASK;
    localparam logic [ADDR_W-1:0] TAG      = BASE & TAG_MASK;

    logic unpriv, nonsec, ifetch;

    // Decode the context bits with their stated polarity.
    always_comb begin
        unpriv = ~prot[PROT_PRIV_BIT];
        nonsec =  prot[PROT_NSEC_BIT];
        ifetch =  prot[PROT_INSTR_BIT];
    end

    // Window match and rule comparison.
    always_comb begin
        hit    = ((addr & TAG_MASK) == TAG);
        breach = (RULE.need_priv   & unpriv) |
                 (RULE.need_secure & nonsec) |
                 (RULE.exec_never  & ifetch);
    end

endmodule

// File: rtl/prot_window_select.sv
`timescale 1ns/1ps
// Picks the lowest-indexed window that matches and reports its verdict.
// Assumes hit_vec/breach_vec come from per-window checkers of equal index.
module prot_window_select #(
    parameter int NUM_WIN = 4
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    input  logic [NUM_WIN-1:0] breach_vec,
    output logic [NUM_WIN-1:0] pick_vec,
    output logic               refuse
);

    // Priority scan: first match wins, later matches are ignored.
    always_comb begin
        logic found;
        found    = 1'b0;
        pick_vec = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (hit_vec[i] && !found) begin
                pick_vec[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    // Verdict of the chosen window; no window means no refusal.
    always_comb begin
        refuse = |(pick_vec & breach_vec);
    end

    // R10: at most one window may decide.
    always_comb begin
        pick_onehot_chk: assert ($onehot0(pick_vec));
    end

    // R4: a refusal always comes from a matched window.
    always_comb begin
        refuse_mapped_chk: assert (!refuse || (|hit_vec));
    end

endmodule

// File: rtl/apb_prot_filter.sv
`timescale 1ns/1ps
// APB region protection filter. Checks the requester context of each
// transfer against a fixed window table, forwards granted transfers
// and completes refused ones locally with an error and zero data.
// Assumes a single manager obeying APB setup/access sequencing.
module apb_prot_filter
    import prot_filter_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_WIN = 4,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE =
        {12'h1C0, 12'h300, 12'h200, 12'h100},
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_MASK =
        {12'h03F, 12'h0FF, 12'h0FF, 12'h0FF},
    parameter logic [NUM_WIN*RULE_W-1:0] WIN_RULE =
        {3'b111, 3'b100, 3'b010, 3'b001}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_psel,
    input  logic              s_penable,
    input  logic              s_pwrite,
    input  logic [ADDR_W-1:0] s_paddr,
    input  logic [DATA_W-1:0] s_pwdata,
    input  logic [PROT_W-1:0] s_pprot,
    output logic              s_pready,
    output logic [DATA_W-1:0] s_prdata,
    output logic              s_pslverr,
    output logic              m_psel,
    output logic              m_penable,
    output logic              m_pwrite,
    output logic [ADDR_W-1:0] m_paddr,
    output logic [DATA_W-1:0] m_pwdata,
    output logic [PROT_W-1:0] m_pprot,
    input  logic              m_pready,
    input  logic [DATA_W-1:0] m_prdata,
    input  logic              m_pslverr
);

    logic [NUM_WIN-1:0] hit_vec, breach_vec, pick_vec;
    logic refuse_now, refuse_q, block_down;
    logic setup_ph, access_ph;

    genvar g;
    generate
        for (g = 0; g < NUM_WIN; g++) begin : g_win
            prot_window_check #(
                .ADDR_W   (ADDR_W),
                .BASE     (WIN_BASE[g*ADDR_W +: ADDR_W]),
                .OFFS_MASK(WIN_MASK[g*ADDR_W +: ADDR_W]),
                .RULE     (win_rule_t'(WIN_RULE[g*RULE_W +: RULE_W]))
            ) u_chk (
                .addr  (s_paddr),
                .prot  (s_pprot),
                .hit   (hit_vec[g]),
                .breach(breach_vec[g])
            );
        end
    endgenerate

    prot_window_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .hit_vec   (hit_vec),
        .breach_vec(breach_vec),
        .pick_vec  (pick_vec),
        .refuse    (refuse_now)
    );

    // Phase decode of the upstream transfer.
    always_comb begin
        setup_ph  = s_psel & ~s_penable;
        access_ph = s_psel &  s_penable;
    end

    // Capture the verdict at setup; hold it until completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                    refuse_q <= 1'b0;
        else if (setup_ph)             refuse_q <= refuse_now;
        else if (access_ph && s_pready) refuse_q <= 1'b0;
    end

    // Downstream side: selection blocked for the whole refused transfer.
    always_comb begin
        block_down = setup_ph ? refuse_now : refuse_q;
        m_psel     = s_psel & ~block_down;
        m_penable  = s_psel & s_penable & ~block_down;
        m_pwrite   = s_pwrite;
        m_paddr    = s_paddr;
        m_pwdata   = s_pwdata;
        m_pprot    = s_pprot;
    end

    // Upstream response: local error on refusal, pass-through on grant.
    always_comb begin
        s_pready  = access_ph & (refuse_q | m_pready);
        s_pslverr = access_ph & (refuse_q | (m_pready & m_pslverr));
        s_prdata  = (access_ph & ~refuse_q) ? m_prdata : '0;
    end

    // R6
    refuse_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ph && refuse_now) ##1 (s_psel && s_penable)
        |-> (s_pready && s_pslverr && s_prdata == '0));

    // R5
    refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_ph && refuse_now) ##1 (s_psel && s_penable)
        |-> (!m_psel && !m_penable));

    // R8
    idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_psel && s_penable && s_pready) |-> !s_pslverr);

    // R7
    grant_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && m_psel)
        |-> (s_pready == m_pready && s_prdata == m_prdata));

    // R9
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && !s_pready) ##1 (s_psel && s_penable)
        |-> $stable(m_psel));

endmodule

// File: tb/apb_prot_filter_test.sv
`timescale 1ns/1ps
module apb_prot_filter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_psel = 1'b0, s_penable = 1'b0, s_pwrite = 1'b0;
    logic [11:0] s_paddr = '0;
    logic [31:0] s_pwdata = '0;
    logic [2:0]  s_pprot = '0;
    logic        s_pready, s_pslverr;
    logic [31:0] s_prdata;
    logic        m_psel, m_penable, m_pwrite, m_pready, m_pslverr;
    logic [11:0] m_paddr;
    logic [31:0] m_pwdata, m_prdata;
    logic [2:0]  m_pprot;

    int checks = 0;
    int errors = 0;
    int wait_n = 0;
    int cnt    = 0;
    bit cur_refuse = 1'b0;
    logic [31:0] mem     [256];
    logic [31:0] ref_mem [256];

    // Window table as stated by the requirements (index 0 first).
    logic [11:0] w_base [4] = '{12'h100, 12'h200, 12'h300, 12'h1C0};
    logic [11:0] w_mask [4] = '{12'h0FF, 12'h0FF, 12'h0FF, 12'h03F};
    logic [2:0]  w_rule [4] = '{3'b001, 3'b010, 3'b100, 3'b111};

    always #5 clk = ~clk;

    apb_prot_filter uut (
        .clk(clk), .rst_n(rst_n),
        .s_psel(s_psel), .s_penable(s_penable), .s_pwrite(s_pwrite),
        .s_paddr(s_paddr), .s_pwdata(s_pwdata), .s_pprot(s_pprot),
        .s_pready(s_pready), .s_prdata(s_prdata), .s_pslverr(s_pslverr),
        .m_psel(m_psel), .m_penable(m_penable), .m_pwrite(m_pwrite),
        .m_paddr(m_paddr), .m_pwdata(m_pwdata), .m_pprot(m_pprot),
        .m_pready(m_pready), .m_prdata(m_prdata), .m_pslverr(m_pslverr)
    );

    // Downstream subordinate model with programmable wait states.
    assign m_pready  = m_psel && m_penable && (cnt == wait_n);
    assign m_prdata  = mem[m_paddr[9:2]];
    assign m_pslverr = m_pready && (m_paddr == 12'h804);

    always @(posedge clk) begin
        if (m_psel && m_penable) begin
            if (cnt == wait_n) begin
                cnt <= 0;
                if (m_pwrite) mem[m_paddr[9:2]] <= m_pwdata;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference verdict: first matching window's rule, else grant.
    function automatic bit ref_refuse(input logic [11:0] a, input logic [2:0] p);
        for (int i = 0; i < 4; i++) begin
            if ((a & ~w_mask[i]) == (w_base[i] & ~w_mask[i]))
                return (w_rule[i][0] && !p[0]) || (w_rule[i][1] && p[1]) ||
                       (w_rule[i][2] && p[2]);
        end
        return 1'b0;
    endfunction

    // Per-cycle monitor: idle error line and silent downstream on refusal.
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            chk(!(!(s_psel && s_penable && s_pready) && s_pslverr), "R8",
                "error outside completion", {31'd0, s_pslverr}, 32'd0);
            if (cur_refuse)
                chk(!m_psel && !m_penable, "R5", "downstream select on refusal",
                    {30'd0, m_psel, m_penable}, 32'd0);
        end
    end

    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [2:0] p, input bit flip, input string req);
        bit dn   = ref_refuse(a, p);
        bit derr = !dn && (a == 12'h804);
        int cyc  = 0;
        @(negedge clk);
        s_psel = 1'b1; s_penable = 1'b0; s_pwrite = wr;
        s_paddr = a; s_pwdata = d; s_pprot = p; cur_refuse = dn;
        @(negedge clk);
        s_penable = 1'b1;
        if (flip) s_pprot = ~p;
        #1;
        while (!s_pready && cyc < 50) begin
            @(negedge clk); #1; cyc++;
        end
        chk(cyc == (dn ? 0 : wait_n), req, "wait cycles", cyc, dn ? 0 : wait_n);
        chk(s_pslverr == (dn | derr), req, "error", {31'd0, s_pslverr}, {31'd0, dn | derr});
        if (!wr)
            chk(s_prdata == (dn ? 32'd0 : ref_mem[a[9:2]]), req, "read data",
                s_prdata, dn ? 32'd0 : ref_mem[a[9:2]]);
        if (wr && !dn && !derr) ref_mem[a[9:2]] = d;
        @(negedge clk);
        s_psel = 1'b0; s_penable = 1'b0; cur_refuse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 32'hA000_0000 + i;
            ref_mem[i] = 32'hA000_0000 + i;
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!s_pready && !s_pslverr && !m_psel, "R8", "reset outputs",
            {29'd0, s_pready, s_pslverr, m_psel}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: privilege window
        wait_n = 0;
        xfer(1, 12'h104, 32'h1111_0001, 3'b001, 0, "R1");
        xfer(0, 12'h104, 0, 3'b001, 0, "R1");
        xfer(1, 12'h104, 32'hDEAD_BEEF, 3'b000, 0, "R5");   // refused write
        xfer(0, 12'h104, 0, 3'b001, 0, "R5");                // unchanged
        xfer(0, 12'h108, 0, 3'b000, 0, "R6");                // refused read

        // R2: secure window with wait states
        wait_n = 2;
        xfer(0, 12'h210, 0, 3'b011, 0, "R2");
        xfer(1, 12'h210, 32'h2222_0002, 3'b000, 0, "R2");
        xfer(0, 12'h210, 0, 3'b001, 0, "R7");

        // R3: execute-never window
        wait_n = 1;
        xfer(0, 12'h320, 0, 3'b101, 0, "R3");
        xfer(0, 12'h320, 0, 3'b001, 0, "R3");
        xfer(1, 12'h324, 32'h3333_0003, 3'b100, 0, "R3");
        xfer(0, 12'h324, 0, 3'b000, 0, "R5");

        // R4: unmapped space, any context; R7 forwarded downstream error
        wait_n = 3;
        xfer(1, 12'h800, 32'h4444_0004, 3'b110, 0, "R4");
        xfer(0, 12'h800, 0, 3'b110, 0, "R4");
        xfer(0, 12'h804, 0, 3'b000, 0, "R7");

        // R10: overlap resolved by lowest window
        wait_n = 0;
        xfer(0, 12'h1C4, 0, 3'b111, 0, "R10");
        xfer(0, 12'h1C4, 0, 3'b110, 0, "R10");

        // R9: context flips during the access phase
        wait_n = 2;
        xfer(0, 12'h10C, 0, 3'b001, 1, "R9");
        xfer(1, 12'h10C, 32'h5555_0005, 3'b000, 1, "R9");
        xfer(0, 12'h10C, 0, 3'b001, 0, "R9");

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule